// File: doc/BRIEF.md
# Interrupt Line State Tracker

This block keeps the delivery state of eight physical interrupt lines. Each line is either level-sensitive or edge-sensitive, selected by a static configuration bit. Each line sits in one of four states: inactive (`LS_IDLE`), pending (`LS_PEND`), active (`LS_ACT`) or pending and active together (`LS_PACT`). From the lines that are pending and not active, the block picks the lowest-numbered one and presents it to a CPU. It also holds a running-priority flag that stays set from the CPU acknowledge until the end-of-interrupt.

End-of-interrupt and deactivation are separate operations. An end-of-interrupt only clears the running-priority flag. The line itself stays active, and so stays hidden from the CPU, until a deactivate arrives. That deactivate can come from the CPU or from a linked virtual entry. Software can also force a line active without an acknowledge. This holds a pending input off the CPU, for example while a guest owns the device. After a deactivate, a level line follows its input again, and an edge line fires again only if an edge arrived while it was active.

Line transitions, evaluated on every clock with {active, pending} as the state code: an edge or an asserted level takes `LS_IDLE` to `LS_PEND`. An acknowledge takes `LS_PEND` to `LS_ACT`, or to `LS_PACT` if the level input is still high or a new edge lands in the same cycle. An edge takes `LS_ACT` to `LS_PACT`. A deactivate takes `LS_PACT` to `LS_PEND` and `LS_ACT` to `LS_IDLE`. A set-active moves any state to its active counterpart. The running-priority machine has the states `RUN_FREE` and `RUN_HELD`. An accepted acknowledge moves it from `RUN_FREE` to `RUN_HELD`, and an end-of-interrupt moves it from `RUN_HELD` to `RUN_FREE`.

Top module: `irq_line_dist`

## Requirements
- R1: After reset, every line is inactive, `pend_vec` and `act_vec` are 0, and `cpu_irq` and `prio_busy` are low.
- R2: On a line with `trig_edge` bit = 1 (edge mode), the input going from 0 in one cycle to 1 in the next makes the line pending at the next clock edge. An input that stays high produces no further event.
- R3: On a line with `trig_edge` bit = 0 (level mode), the pending bit follows the input one clock later. It clears if the input drops, including before any acknowledge.
- R4: `cpu_irq` is high exactly when some line is pending and not active and `prio_busy` is low. `cpu_id` is then the lowest such line index.
- R5: A line that is active is never the one signalled, even if it is also pending.
- R6: `ack` while `cpu_irq` is high makes line `cpu_id` active and sets `prio_busy`. An edge line's pending bit clears, and a level line's pending bit stays set while its input is high. `ack` while `cpu_irq` is low has no effect.
- R7: `eoi` clears `prio_busy` and leaves every line's pending and active bits unchanged.
- R8: A deactivate on an active edge line moves it from pending+active to pending, and from active to inactive.
- R9: A deactivate on an active level line leaves it pending afterwards only if its input is still asserted.
- R10: An edge arriving on an active edge line moves it to pending+active without signalling the CPU.
- R11: `set_act_valid` makes line `set_act_id` active without an acknowledge. It keeps any pending state and leaves `prio_busy` unchanged.
- R12: A deactivate aimed at a line that is not active changes no line state.
- R13: In one cycle, a deactivate together with a new edge on the same active line leaves it pending and not active, and a set-active together with a deactivate leaves the line active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Raw interrupt inputs, one per line |
| trig_edge | input | 8 | Per-line trigger mode: 1 edge, 0 level |
| ack | input | 1 | CPU acknowledge of the signalled line |
| eoi | input | 1 | End-of-interrupt (priority drop only) |
| set_act_valid | input | 1 | Software set-active strobe |
| set_act_id | input | 3 | Line to force active |
| deact_valid | input | 1 | Deactivate strobe (CPU or linked virtual entry) |
| deact_id | input | 3 | Line to deactivate |
| cpu_irq | output | 1 | Interrupt signal to the CPU |
| cpu_id | output | 3 | Index of the signalled line (0 when none) |
| prio_busy | output | 1 | Running priority held between acknowledge and end-of-interrupt |
| pend_vec | output | 8 | Pending bit of each line |
| act_vec | output | 8 | Active bit of each line |

## Verification
The tricky overlap is a deactivate landing in the same cycle as a new input event on the same line. This can be a fresh edge, a still-high level input, or a set-active. The outcome then depends on which term wins in the next-state logic. Directed sequences create each pairing on purpose: an edge together with a deactivate on an active line, and a set-active together with a deactivate. Constrained random traffic then produces further collisions with acknowledges and end-of-interrupts. Each result is judged on `pend_vec` and `act_vec` one clock later, against a bitwise model in the bench.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

    // Encoding is {active, pending}
    typedef enum logic [1:0] {
        LS_IDLE = 2'b00,
        LS_PEND = 2'b01,
        LS_ACT  = 2'b10,
        LS_PACT = 2'b11
    } line_st_t;

    typedef enum logic {
        RUN_FREE = 1'b0,
        RUN_HELD = 1'b1
    } run_st_t;

endpackage

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
    import irq_dist_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic edge_mode,
    input  logic raw_in,
    input  logic ack_hit,
    input  logic set_act,
    input  logic deact,
    output logic is_pend,
    output logic is_act
);

    line_st_t st_q;
    line_st_t st_d;
    logic     prev_q;
    logic     edge_evt;
    logic     pin;
    logic     p_n;
    logic     a_n;

    assign edge_evt = raw_in && !prev_q;
    assign pin      = edge_mode ? edge_evt : raw_in;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= LS_IDLE;
            prev_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            prev_q <= raw_in;
        end
    end

    // next state
    always_comb begin
        p_n = 1'b0;
        a_n = 1'b0;
        unique case (st_q)
            LS_IDLE: begin
                p_n = pin;
                a_n = set_act;
            end
            LS_PEND: begin
                p_n = edge_mode ? (!ack_hit || edge_evt) : raw_in;
                a_n = ack_hit || set_act;
            end
            LS_ACT: begin
                p_n = pin;
                a_n = !deact || set_act;
            end
            LS_PACT: begin
                p_n = edge_mode ? 1'b1 : raw_in;
                a_n = !deact || set_act;
            end
        endcase
        st_d = line_st_t'({a_n, p_n});
    end

    // outputs
    always_comb begin
        is_pend = (st_q == LS_PEND) || (st_q == LS_PACT);
        is_act  = (st_q == LS_ACT)  || (st_q == LS_PACT);
    end

    // R3
    lvl_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode && raw_in) |=> is_pend);

    // R8
    pact_deact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LS_PACT && edge_mode && deact && !set_act) |=> (st_q == LS_PEND));

    // R10
    edge_on_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && is_act && edge_evt && !deact) |=> (st_q == LS_PACT));

    // R12
    idle_deact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LS_IDLE && deact && !set_act && !pin) |=> (st_q == LS_IDLE));

    // R6
    ack_to_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit |=> is_act);

endmodule

// File: rtl/irq_pick_low.sv
module irq_pick_low #(
    parameter int N_LINES = 8,
    localparam int IDW = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0] req,
    output logic               found,
    output logic [IDW-1:0]     sel
);

    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                sel   = IDW'(i);
            end
        end
    end

    // R4
    pick_valid_chk: assert final (!found || req[sel]);

endmodule

// File: rtl/irq_run_tracker.sv
module irq_run_tracker
    import irq_dist_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic eoi,
    output logic busy
);

    run_st_t st_q;
    run_st_t st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RUN_FREE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RUN_FREE: if (take) st_d = RUN_HELD;
            RUN_HELD: if (eoi)  st_d = RUN_FREE;
        endcase
    end

    always_comb busy = (st_q == RUN_HELD);

    // R7
    eoi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !take) |=> !busy);

    // R6
    take_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> busy);

endmodule

// File: rtl/irq_line_dist.sv
module irq_line_dist #(
    parameter int N_LINES = 8,
    localparam int IDW = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_in,
    input  logic [N_LINES-1:0] trig_edge,
    input  logic               ack,
    input  logic               eoi,
    input  logic               set_act_valid,
    input  logic [IDW-1:0]     set_act_id,
    input  logic               deact_valid,
    input  logic [IDW-1:0]     deact_id,
    output logic               cpu_irq,
    output logic [IDW-1:0]     cpu_id,
    output logic               prio_busy,
    output logic [N_LINES-1:0] pend_vec,
    output logic [N_LINES-1:0] act_vec
);

    logic [N_LINES-1:0] eligible;
    logic               found;
    logic [IDW-1:0]     sel;
    logic               ack_ok;

    assign eligible = pend_vec & ~act_vec;
    assign cpu_irq  = found && !prio_busy;
    assign cpu_id   = found ? sel : '0;
    assign ack_ok   = ack && cpu_irq;

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        irq_line_fsm u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .edge_mode (trig_edge[g]),
            .raw_in    (irq_in[g]),
            .ack_hit   (ack_ok && (sel == IDW'(g))),
            .set_act   (set_act_valid && (set_act_id == IDW'(g))),
            .deact     (deact_valid && (deact_id == IDW'(g))),
            .is_pend   (pend_vec[g]),
            .is_act    (act_vec[g])
        );
    end

    irq_pick_low #(.N_LINES(N_LINES)) u_pick (
        .req   (eligible),
        .found (found),
        .sel   (sel)
    );

    irq_run_tracker u_run (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (ack_ok),
        .eoi   (eoi),
        .busy  (prio_busy)
    );

    // R5
    no_active_signal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> !act_vec[cpu_id]);

    // R4
    busy_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prio_busy |-> !cpu_irq);

    // R11
    set_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_act_valid |=> act_vec[$past(set_act_id)]);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (act_vec == '0 && pend_vec == '0 && !prio_busy));

endmodule

// File: tb/irq_line_dist_tb.sv
module irq_line_dist_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic [7:0] trig_edge = 8'h0F;
    logic       ack = 1'b0;
    logic       eoi = 1'b0;
    logic       set_act_valid = 1'b0;
    logic [2:0] set_act_id = '0;
    logic       deact_valid = 1'b0;
    logic [2:0] deact_id = '0;
    logic       cpu_irq;
    logic [2:0] cpu_id;
    logic       prio_busy;
    logic [7:0] pend_vec;
    logic [7:0] act_vec;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0] m_pend, m_act, m_prev;
    logic       m_busy;

    always #2.5 clk = ~clk;

    irq_line_dist dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .trig_edge(trig_edge),
        .ack(ack), .eoi(eoi), .set_act_valid(set_act_valid), .set_act_id(set_act_id),
        .deact_valid(deact_valid), .deact_id(deact_id), .cpu_irq(cpu_irq),
        .cpu_id(cpu_id), .prio_busy(prio_busy), .pend_vec(pend_vec), .act_vec(act_vec)
    );

    function automatic logic [3:0] m_pick();
        for (int i = 0; i < 8; i++)
            if (m_pend[i] && !m_act[i]) return {1'b1, 3'(i)};
        return 4'b0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic step();
        logic [3:0] pk;
        logic       m_irq;
        logic [7:0] evt, p_n, a_n, ah, sa, dv;
        pk    = m_pick();
        m_irq = pk[3] && !m_busy;
        evt   = irq_in & ~m_prev;
        ah    = (ack && m_irq) ? (8'h01 << pk[2:0]) : 8'h00;
        sa    = set_act_valid ? (8'h01 << set_act_id) : 8'h00;
        dv    = deact_valid ? (8'h01 << deact_id) : 8'h00;
        p_n   = (trig_edge & ((m_pend & ~ah) | evt)) | (~trig_edge & irq_in);
        a_n   = (m_act & ~dv) | ah | sa;
        @(posedge clk);
        m_pend = p_n;
        m_act  = a_n;
        m_prev = irq_in;
        if (ack && m_irq) m_busy = 1'b1;
        else if (eoi)     m_busy = 1'b0;
        @(negedge clk);
        pk    = m_pick();
        m_irq = pk[3] && !m_busy;
        chk("R4 cpu_irq", cpu_irq, m_irq);
        chk("R4 cpu_id", cpu_id, m_irq ? pk[2:0] : pk[2:0] & {3{pk[3]}});
        chk("R6 prio_busy", prio_busy, m_busy);
        chk("R2 R3 pend_vec", pend_vec, m_pend);
        chk("R6 act_vec", act_vec, m_act);
        ack = 0; eoi = 0; set_act_valid = 0; deact_valid = 0;
    endtask

    task automatic do_deact(input logic [2:0] id);
        deact_valid = 1; deact_id = id;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        m_pend = 0; m_act = 0; m_prev = 0; m_busy = 0;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 pend", pend_vec, 0);
        chk("R1 act", act_vec, 0);
        chk("R1 irq", cpu_irq, 0);
        chk("R1 busy", prio_busy, 0);

        irq_in[2] = 1; step();
        chk("R2 edge pend", pend_vec, 8'h04);
        chk("R4 id", cpu_id, 2);
        step();
        chk("R2 held high", pend_vec, 8'h04);
        irq_in[5] = 1; step();
        chk("R3 level pend", pend_vec, 8'h24);
        chk("R4 lowest", cpu_id, 2);
        ack = 1; step();
        chk("R6 act", act_vec, 8'h04);
        chk("R2 no refire", pend_vec, 8'h20);
        chk("R6 busy", prio_busy, 1);
        chk("R4 masked", cpu_irq, 0);
        irq_in[2] = 0; step();
        irq_in[2] = 1; step();
        chk("R10 pact pend", pend_vec, 8'h24);
        chk("R10 pact act", act_vec, 8'h04);
        eoi = 1; step();
        chk("R7 busy", prio_busy, 0);
        chk("R7 act kept", act_vec, 8'h04);
        chk("R5 skip active", cpu_id, 5);
        do_deact(2); step();
        chk("R8 pact->pend act", act_vec, 8'h00);
        chk("R8 pact->pend pend", pend_vec, 8'h24);
        chk("R8 refire id", cpu_id, 2);
        ack = 1; step();
        eoi = 1; step();
        irq_in[2] = 0; do_deact(2); step();
        chk("R8 act->idle act", act_vec, 8'h00);
        chk("R8 act->idle pend", pend_vec, 8'h20);
        do_deact(6); step();
        chk("R12 pend", pend_vec, 8'h20);
        chk("R12 act", act_vec, 8'h00);
        chk("R12 id", cpu_id, 5);
        ack = 1; step();
        chk("R6 level keep pend", pend_vec, 8'h20);
        eoi = 1; step();
        chk("R5 pact hidden", cpu_irq, 0);
        do_deact(5); step();
        chk("R9 resample high", pend_vec, 8'h20);
        chk("R9 refire", cpu_irq, 1);
        ack = 1; step();
        eoi = 1; step();
        irq_in[5] = 0; step();
        chk("R3 drop", pend_vec, 8'h00);
        do_deact(5); step();
        chk("R9 resample low act", act_vec, 8'h00);
        chk("R9 resample low irq", cpu_irq, 0);
        ack = 1; step();
        chk("R6 ack ignored", prio_busy, 0);
        irq_in[4] = 1; set_act_valid = 1; set_act_id = 4; step();
        chk("R11 act", act_vec, 8'h10);
        chk("R11 pend kept", pend_vec, 8'h10);
        chk("R11 busy", prio_busy, 0);
        chk("R11 hidden", cpu_irq, 0);
        irq_in[4] = 0; do_deact(4); step();
        set_act_valid = 1; set_act_id = 1; step();
        irq_in[1] = 1; do_deact(1); step();
        chk("R13 edge+deact act", act_vec, 8'h00);
        chk("R13 edge+deact pend", pend_vec, 8'h02);
        set_act_valid = 1; set_act_id = 1; step();
        set_act_valid = 1; set_act_id = 1; do_deact(1); step();
        chk("R13 set wins", act_vec, 8'h02);
        irq_in[1] = 0; do_deact(1); step();
        ack = 1; step();
        eoi = 1; step();
        do_deact(1); step();

        for (int k = 0; k < 4000; k++) begin
            irq_in ^= 8'($urandom & $urandom & $urandom);
            ack = ($urandom % 10) < 3;
            eoi = ($urandom % 10) < 2;
            deact_valid = ($urandom % 4) == 0;
            deact_id = 3'($urandom);
            set_act_valid = ($urandom % 20) == 0;
            set_act_id = 3'($urandom);
            step();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule